// File: doc/BRIEF.md
# Snoop-Invalidate Direct-Mapped Scalar Cache

This block is a direct-mapped data cache that holds scalar operands for one processor of a vector multiprocessor node. The data words and the per-line valid bits are selected by the page-offset part of the virtual address. A separate array records, for each line, the physical page number of the data it holds. The cache is exactly one page in size, so the line index lies entirely within the page offset and needs no translation. The processor port therefore supplies the virtual page offset together with a physical page number that an external translator provides.

Loads that hit return a word on the next cycle. Loads that miss raise a line-fill request carrying the physical line address. When the whole line comes back in one beat, the block writes the data, the physical page number and the valid bit together. Stores are write-through: each one leaves on a store port in the cycle it is accepted. A store that hits also updates the cached word, and a store that misses allocates nothing.

Two further inputs keep the cache coherent, and both are looked up only in the physical array. One carries the line addresses of writes made by remote processors. The other carries the line addresses of vector loads and stores, which bypass the cache. When either names a line the cache holds, that line is invalidated in one cycle, and neither input can be stalled.

Top module: `scalar_snoop_cache`

## Requirements
- R1: A synchronous reset clears every valid bit, leaves `cpu_ready` high and `mem_req`/`cpu_rvalid` low, and makes every later load miss until that line is refilled.
- R2: A load that hits returns the word on `cpu_rvalid`/`cpu_rdata` one cycle after acceptance and raises no `mem_req`.
- R3: A load that misses drops `cpu_ready` and holds `mem_req` with `mem_addr` = {physical page, index = offset[11:5], 5'b0} until `mem_fill_valid`. The fill writes the line, where word w is `mem_fill_data[32*w +: 32]`, together with its page number and valid bit. The requested word, selected by offset[4:2], appears on `cpu_rdata` with `cpu_rvalid` one cycle after the fill beat.
- R4: A hit needs both the valid bit and a match between the stored page number and `cpu_ptag`. The same index with another page number misses.
- R5: A store is presented in the cycle it is accepted on `mem_wr_valid`, with `mem_wr_addr` = {`cpu_ptag`, `cpu_voff`} and `mem_wr_data` = `cpu_wdata`. A store that hits replaces the cached word.
- R6: A store that misses changes neither data nor valid bits. A later load of the previously cached line at that index still hits with its old data.
- R7: A remote-write line address (`snp_line` = {page, index}) that matches a valid line clears that line. One that carries a different page number leaves the line valid.
- R8: A vector line address (`vec_line`) that matches a valid line clears it. Vector accesses never raise `mem_req`, and a non-matching one leaves the line valid.
- R9: When a fill beat and a remote-write or vector address fall in the same cycle, both at the fill's index, a match with the fill's line address leaves the line invalid. The load still receives its word. A different page number at that index lets the fill set the line valid.
- R10: Invalidations take effect one cycle after they are presented, on back-to-back cycles and while a fill is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_voff | input | 12 | Virtual page offset (byte address within page) |
| cpu_ptag | input | 20 | Physical page number from the translator |
| cpu_wdata | input | 32 | Store data |
| cpu_ready | output | 1 | Block can accept an access (no fill outstanding) |
| cpu_rvalid | output | 1 | Load data valid |
| cpu_rdata | output | 32 | Load data |
| mem_req | output | 1 | Line fill request, held until the fill beat |
| mem_addr | output | 32 | Physical line address of the fill |
| mem_fill_valid | input | 1 | Fill data beat |
| mem_fill_data | input | 256 | Whole line, word w in bits 32*w+31..32*w |
| mem_wr_valid | output | 1 | Write-through store valid |
| mem_wr_addr | output | 32 | Physical byte address of the store |
| mem_wr_data | output | 32 | Store data |
| snp_valid | input | 1 | Remote processor write observed |
| snp_line | input | 27 | Physical line address of the remote write |
| vec_valid | input | 1 | Vector load or store observed |
| vec_line | input | 27 | Physical line address of the vector access |

## Verification
Two functions can fall on the same cycle and contend for the same valid bit: a returning fill and an invalidation aimed at the line being filled. The bench provokes this by holding a load miss open and presenting a remote-write address, and in a second case a vector address, during the very beat that carries the fill data. It judges the outcome at the ports. The load must still get its word, and a following load must miss when the invalidating address equals the fill's line address. When only the index agrees and the page number differs, the following load must hit.

// File: rtl/scalar_snoop_cache.sv
module scalar_snoop_cache #(
  parameter int PAGE_BYTES = 4096,
  parameter int LINE_BYTES = 32,
  parameter int PA_W       = 32,
  parameter int DW         = 32
) (
  input  logic                                        clk,
  input  logic                                        rst,
  input  logic                                        cpu_req,
  input  logic                                        cpu_we,
  input  logic [$clog2(PAGE_BYTES)-1:0]               cpu_voff,
  input  logic [PA_W-$clog2(PAGE_BYTES)-1:0]          cpu_ptag,
  input  logic [DW-1:0]                               cpu_wdata,
  output logic                                        cpu_ready,
  output logic                                        cpu_rvalid,
  output logic [DW-1:0]                               cpu_rdata,
  output logic                                        mem_req,
  output logic [PA_W-1:0]                             mem_addr,
  input  logic                                        mem_fill_valid,
  input  logic [LINE_BYTES*8-1:0]                     mem_fill_data,
  output logic                                        mem_wr_valid,
  output logic [PA_W-1:0]                             mem_wr_addr,
  output logic [DW-1:0]                               mem_wr_data,
  input  logic                                        snp_valid,
  input  logic [PA_W-$clog2(LINE_BYTES)-1:0]          snp_line,
  input  logic                                        vec_valid,
  input  logic [PA_W-$clog2(LINE_BYTES)-1:0]          vec_line
);

  localparam int PO_W  = $clog2(PAGE_BYTES);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int IDX_W = PO_W - OFF_W;
  localparam int LINES = 1 << IDX_W;
  localparam int WPL   = LINE_BYTES * 8 / DW;
  localparam int WSEL  = $clog2(WPL);
  localparam int BSEL  = $clog2(DW / 8);
  localparam int TAG_W = PA_W - PO_W;

  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tag_q  [LINES];
  logic [DW-1:0]    data_q [LINES*WPL];

  logic             busy_q;
  logic [IDX_W-1:0] miss_idx_q;
  logic [TAG_W-1:0] miss_tag_q;
  logic [WSEL-1:0]  miss_word_q;
  logic             rvalid_q;
  logic [DW-1:0]    rdata_q;

  logic [IDX_W-1:0] c_idx, s_idx, v_idx;
  logic [WSEL-1:0]  c_word;
  logic [TAG_W-1:0] s_tag, v_tag;
  logic             accept, lhit, rd_hit, rd_miss, st_hit, fill_fire;
  logic             s_hit, v_hit, s_kill, v_kill, s_clr, v_clr;

  assign c_idx  = cpu_voff[PO_W-1:OFF_W];
  assign c_word = cpu_voff[OFF_W-1:BSEL];
  assign s_idx  = snp_line[IDX_W-1:0];
  assign s_tag  = snp_line[PA_W-OFF_W-1:IDX_W];
  assign v_idx  = vec_line[IDX_W-1:0];
  assign v_tag  = vec_line[PA_W-OFF_W-1:IDX_W];

  assign cpu_ready = !busy_q;
  assign accept    = cpu_req && cpu_ready;
  assign lhit      = valid_q[c_idx] && (tag_q[c_idx] == cpu_ptag);
  assign rd_hit    = accept && !cpu_we && lhit;
  assign rd_miss   = accept && !cpu_we && !lhit;
  assign st_hit    = accept && cpu_we && lhit;
  assign fill_fire = busy_q && mem_fill_valid;

  assign s_hit  = snp_valid && valid_q[s_idx] && (tag_q[s_idx] == s_tag);
  assign v_hit  = vec_valid && valid_q[v_idx] && (tag_q[v_idx] == v_tag);
  assign s_kill = snp_valid && (s_idx == miss_idx_q) && (s_tag == miss_tag_q);
  assign v_kill = vec_valid && (v_idx == miss_idx_q) && (v_tag == miss_tag_q);
  assign s_clr  = s_hit && !(fill_fire && (s_idx == miss_idx_q));
  assign v_clr  = v_hit && !(fill_fire && (v_idx == miss_idx_q));

  assign mem_req     = busy_q;
  assign mem_addr    = {miss_tag_q, miss_idx_q, {OFF_W{1'b0}}};
  assign mem_wr_valid = accept && cpu_we;
  assign mem_wr_addr = {cpu_ptag, cpu_voff};
  assign mem_wr_data = cpu_wdata;
  assign cpu_rvalid  = rvalid_q;
  assign cpu_rdata   = rdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= '0;
      busy_q   <= 1'b0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_hit || fill_fire;
      if (rd_miss) busy_q <= 1'b1;
      else if (fill_fire) busy_q <= 1'b0;
      if (fill_fire) valid_q[miss_idx_q] <= !(s_kill || v_kill);
      if (s_clr) valid_q[s_idx] <= 1'b0;
      if (v_clr) valid_q[v_idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_miss) begin
      miss_idx_q  <= c_idx;
      miss_tag_q  <= cpu_ptag;
      miss_word_q <= c_word;
    end
    if (rd_hit) rdata_q <= data_q[{c_idx, c_word}];
    else if (fill_fire) rdata_q <= mem_fill_data[miss_word_q*DW +: DW];
    if (fill_fire) begin
      tag_q[miss_idx_q] <= miss_tag_q;
      for (int w = 0; w < WPL; w++)
        data_q[{miss_idx_q, w[WSEL-1:0]}] <= mem_fill_data[w*DW +: DW];
    end
    if (st_hit) data_q[{c_idx, c_word}] <= cpu_wdata;
  end

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (valid_q == '0) && !mem_req && !cpu_rvalid);

  p_hit_returns_r2: assert property (@(posedge clk) disable iff (rst)
    rd_hit |=> cpu_rvalid && !mem_req);

  p_miss_request_r3: assert property (@(posedge clk) disable iff (rst)
    rd_miss |=> mem_req && !cpu_ready &&
      (mem_addr == {$past(cpu_ptag), $past(c_idx), {OFF_W{1'b0}}}));

  p_fill_hold_r3: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_fill_valid |=> mem_req && $stable(mem_addr));

  p_fill_data_r3: assert property (@(posedge clk) disable iff (rst)
    fill_fire |=> cpu_rvalid && !mem_req);

  p_store_miss_r6: assert property (@(posedge clk) disable iff (rst)
    accept && cpu_we && !lhit && !snp_valid && !vec_valid |=> $stable(valid_q));

  p_snoop_clear_r7: assert property (@(posedge clk) disable iff (rst)
    s_hit && !fill_fire |=> !valid_q[$past(s_idx)]);

  p_vector_clear_r8: assert property (@(posedge clk) disable iff (rst)
    v_hit && !fill_fire |=> !valid_q[$past(v_idx)]);

  p_fill_kill_r9: assert property (@(posedge clk) disable iff (rst)
    fill_fire && (s_kill || v_kill) |=> !valid_q[$past(miss_idx_q)]);

  p_fill_set_r9: assert property (@(posedge clk) disable iff (rst)
    fill_fire && !s_kill && !v_kill |=> valid_q[$past(miss_idx_q)]);

endmodule

// File: tb/scalar_snoop_cache_tb.sv
module scalar_snoop_cache_tb;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cpu_req = 1'b0, cpu_we = 1'b0;
  logic [11:0]  cpu_voff = '0;
  logic [19:0]  cpu_ptag = '0;
  logic [31:0]  cpu_wdata = '0;
  logic         cpu_ready, cpu_rvalid;
  logic [31:0]  cpu_rdata;
  logic         mem_req;
  logic [31:0]  mem_addr;
  logic         mem_fill_valid = 1'b0;
  logic [255:0] mem_fill_data = '0;
  logic         mem_wr_valid;
  logic [31:0]  mem_wr_addr, mem_wr_data;
  logic         snp_valid = 1'b0, vec_valid = 1'b0;
  logic [26:0]  snp_line = '0, vec_line = '0;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  scalar_snoop_cache u_dut (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_voff(cpu_voff), .cpu_ptag(cpu_ptag), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_fill_valid(mem_fill_valid),
    .mem_fill_data(mem_fill_data), .mem_wr_valid(mem_wr_valid),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .snp_valid(snp_valid), .snp_line(snp_line),
    .vec_valid(vec_valid), .vec_line(vec_line)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [255:0] line_of(input logic [15:0] seed);
    logic [255:0] l;
    for (int w = 0; w < 8; w++) l[w*32 +: 32] = {seed, 16'(w)};
    return l;
  endfunction

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic rd_hit(input logic [11:0] off, input logic [19:0] pt, input logic [31:0] exp, input string req);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_voff = off; cpu_ptag = pt;
    step();
    cpu_req = 1'b0;
    chk(cpu_rvalid === 1'b1, req, {31'd0, cpu_rvalid}, 32'd1);
    chk(cpu_rdata === exp, req, cpu_rdata, exp);
    chk(mem_req === 1'b0, req, {31'd0, mem_req}, 32'd0);
  endtask

  task automatic rd_miss(input logic [11:0] off, input logic [19:0] pt, input logic [15:0] seed, input string req,
                         input logic sv, input logic [26:0] sl, input logic vv, input logic [26:0] vl);
    logic [31:0] ea;
    ea = {pt, off[11:5], 5'd0};
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_voff = off; cpu_ptag = pt;
    step();
    cpu_req = 1'b0;
    chk(cpu_rvalid === 1'b0, req, {31'd0, cpu_rvalid}, 32'd0);
    chk(mem_req === 1'b1 && cpu_ready === 1'b0, req, {31'd0, mem_req}, 32'd1);
    chk(mem_addr === ea, req, mem_addr, ea);
    step();
    chk(mem_req === 1'b1 && mem_addr === ea, "R3 hold", mem_addr, ea);
    mem_fill_valid = 1'b1; mem_fill_data = line_of(seed);
    snp_valid = sv; snp_line = sl; vec_valid = vv; vec_line = vl;
    step();
    mem_fill_valid = 1'b0; snp_valid = 1'b0; vec_valid = 1'b0;
    chk(cpu_rvalid === 1'b1 && mem_req === 1'b0, "R3 fill done", {31'd0, cpu_rvalid}, 32'd1);
    chk(cpu_rdata === {seed, 13'd0, off[4:2]}, "R3 fill word", cpu_rdata, {seed, 13'd0, off[4:2]});
  endtask

  task automatic rd_miss0(input logic [11:0] off, input logic [19:0] pt, input logic [15:0] seed, input string req);
    rd_miss(off, pt, seed, req, 1'b0, '0, 1'b0, '0);
  endtask

  task automatic store(input logic [11:0] off, input logic [19:0] pt, input logic [31:0] d, input string req);
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_voff = off; cpu_ptag = pt; cpu_wdata = d;
    #1;
    chk(mem_wr_valid === 1'b1, req, {31'd0, mem_wr_valid}, 32'd1);
    chk(mem_wr_addr === {pt, off} && mem_wr_data === d, req, mem_wr_addr, {pt, off});
    step();
    cpu_req = 1'b0; cpu_we = 1'b0;
    chk(cpu_rvalid === 1'b0 && mem_req === 1'b0, req, {31'd0, mem_req}, 32'd0);
  endtask

  task automatic t_reset();
    chk(cpu_ready === 1'b1 && mem_req === 1'b0 && cpu_rvalid === 1'b0, "R1 idle", {29'd0, cpu_ready, mem_req, cpu_rvalid}, 32'd4);
    rd_miss0(12'h040, 20'h12345, 16'h0001, "R1 miss after reset");
  endtask

  task automatic t_hit();
    rd_hit(12'h04C, 20'h12345, {16'h0001, 16'd3}, "R2 hit word3");
    rd_hit(12'h05C, 20'h12345, {16'h0001, 16'd7}, "R2 hit word7");
  endtask

  task automatic t_tag();
    rd_miss0(12'h044, 20'h54321, 16'h0002, "R4 other page misses");
    rd_miss0(12'h040, 20'h12345, 16'h0003, "R4 refill first page");
    rd_hit(12'h044, 20'h12345, {16'h0003, 16'd1}, "R4 hit after refill");
  endtask

  task automatic t_store();
    store(12'h048, 20'h12345, 32'hDEADBEEF, "R5 write-through");
    rd_hit(12'h048, 20'h12345, 32'hDEADBEEF, "R5 store hit updates");
    rd_hit(12'h04C, 20'h12345, {16'h0003, 16'd3}, "R5 neighbour untouched");
  endtask

  task automatic t_store_miss();
    store(12'h0A0, 20'h11111, 32'h0000CAFE, "R6 store to empty line");
    rd_miss0(12'h0A0, 20'h11111, 16'h0004, "R6 no allocate");
    store(12'h0A0, 20'h22222, 32'h0000BEEF, "R6 store other page");
    rd_hit(12'h0A0, 20'h11111, {16'h0004, 16'd0}, "R6 line unchanged");
  endtask

  task automatic t_snoop();
    snp_valid = 1'b1; snp_line = {20'h99999, 7'd2};
    step(); snp_valid = 1'b0;
    rd_hit(12'h040, 20'h12345, {16'h0003, 16'd0}, "R7 other page keeps line");
    snp_valid = 1'b1; snp_line = {20'h12345, 7'd2};
    step(); snp_valid = 1'b0;
    rd_miss0(12'h040, 20'h12345, 16'h0005, "R7 snoop invalidates");
  endtask

  task automatic t_vector();
    vec_valid = 1'b1; vec_line = {20'h12345, 7'd2};
    step(); vec_valid = 1'b0;
    chk(mem_req === 1'b0, "R8 vector no fill", {31'd0, mem_req}, 32'd0);
    rd_miss0(12'h040, 20'h12345, 16'h0006, "R8 vector invalidates");
    vec_valid = 1'b1; vec_line = {20'h12346, 7'd2};
    step(); vec_valid = 1'b0;
    chk(mem_req === 1'b0, "R8 vector no fill", {31'd0, mem_req}, 32'd0);
    rd_hit(12'h040, 20'h12345, {16'h0006, 16'd0}, "R8 other page keeps line");
  endtask

  task automatic t_race();
    rd_miss(12'h0E0, 20'h0AAAA, 16'h0007, "R9 snoop on fill", 1'b1, {20'h0AAAA, 7'd7}, 1'b0, '0);
    rd_miss(12'h0E0, 20'h0AAAA, 16'h0008, "R9 line left invalid", 1'b1, {20'h0BBBB, 7'd7}, 1'b0, '0);
    rd_hit(12'h0E4, 20'h0AAAA, {16'h0008, 16'd1}, "R9 other page lets fill set");
    vec_valid = 1'b1; vec_line = {20'h0AAAA, 7'd7};
    step(); vec_valid = 1'b0;
    rd_miss(12'h0E0, 20'h0AAAA, 16'h0009, "R9 vector on fill", 1'b0, '0, 1'b1, {20'h0AAAA, 7'd7});
    rd_miss0(12'h0E0, 20'h0AAAA, 16'h000A, "R9 vector kill left invalid");
  endtask

  task automatic t_b2b();
    snp_valid = 1'b1; snp_line = {20'h12345, 7'd2};
    step();
    snp_line = {20'h11111, 7'd5};
    step(); snp_valid = 1'b0;
    rd_miss0(12'h040, 20'h12345, 16'h000B, "R10 first of pair");
    rd_miss0(12'h0A0, 20'h11111, 16'h000C, "R10 second of pair");
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_voff = 12'h120; cpu_ptag = 20'h33333;
    step(); cpu_req = 1'b0;
    snp_valid = 1'b1; snp_line = {20'h11111, 7'd5};
    step(); snp_valid = 1'b0;
    chk(mem_req === 1'b1, "R10 fill outstanding", {31'd0, mem_req}, 32'd1);
    mem_fill_valid = 1'b1; mem_fill_data = line_of(16'h000D);
    step(); mem_fill_valid = 1'b0;
    chk(cpu_rdata === {16'h000D, 16'd0}, "R10 fill word", cpu_rdata, {16'h000D, 16'd0});
    rd_miss0(12'h0A0, 20'h11111, 16'h000E, "R10 snoop during fill");
    rd_hit(12'h120, 20'h33333, {16'h000D, 16'd0}, "R10 filled line intact");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_hit();
    t_tag();
    t_store();
    t_store_miss();
    t_snoop();
    t_vector();
    t_race();
    t_b2b();
    step();
    rst = 1'b1;
    step();
    rst = 1'b0;
    rd_miss0(12'h120, 20'h33333, 16'h000F, "R1 reset clears valid");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule